// File: doc/BRIEF.md
# Record-Aware Stream Channel Controller

This block steers one byte stream from an input FIFO to an output FIFO. Each input byte carries two tag bits, marking the last byte of a record and the last byte of a transfer. In processing mode every byte is handed to an external processing core over a valid/ready handshake, and the core's results are forwarded to the output. In bypass mode bytes go through a one-entry holding register and leave unchanged.

A configuration write sets four bits together: the run enable, the bypass select, stop-at-record and stop-at-transfer. The channel can halt itself at a record or transfer boundary by clearing its own run bit. Mode changes are refused unless the channel is stopped and drained. Any accepted mode change pulses a reset strobe for the core's dictionary. Toggling run does not pulse it.

The block counts bytes written to the output. It keeps sticky end-of-record and end-of-transfer flags, which software clears by writing 1. It also reports an empty flag and a standby indication.

Top module: `stream_chan_ctl`

## Requirements
- R1: After reset, run, bypass, mode_err, eor_irq and eot_irq read 0, byte_cnt reads 0, empty reads 1 and in_ready is 0.
- R2: While run is 0, no byte is taken from the input (in_ready stays 0). While run is 1, a byte is taken whenever one is offered and the downstream path has room.
- R3: In bypass mode (bypass = 1) output bytes equal input bytes in order, and core_valid stays 0.
- R4: In processing mode (bypass = 0) each input byte is presented on core_data, and each core result is written to the output in order, together with its tags.
- R5: A configuration write that would change bypass while run is 1 or empty is 0 leaves bypass unchanged and sets the sticky mode_err. A clr_err pulse clears mode_err.
- R6: dict_clr pulses for exactly one cycle, in the cycle after an accepted bypass change. A write that only changes run, or rewrites the same bypass value, produces no pulse.
- R7: With stop_rec = 1, the cycle after the channel takes a byte tagged in_eor = 1 or in_eot = 1, run reads 0 and no further byte is taken.
- R8: With stop_xfer = 1 and stop_rec = 0, a byte tagged only in_eor does not stop the channel. A byte tagged in_eot = 1 stops it in the same way as R7.
- R9: empty is 0 while any byte that was taken has not yet been written to the output, and 1 once all such bytes are written.
- R10: standby is 1 in a cycle where run is 1 and the channel neither takes an input byte nor writes an output byte.
- R11: byte_cnt rises by one per byte written to the output. A rising run write clears it only if the last halt was caused by an in_eot byte; a restart after a record halt keeps the count.
- R12: Writing a byte to the output with out_eor or out_eot set makes eor_irq 1. Writing one with out_eot set makes eot_irq 1. clr_eor and clr_eot pulses clear the respective flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run enable value written |
| cfg_bypass | input | 1 | Bypass select value written |
| cfg_stop_rec | input | 1 | Stop-at-record value written |
| cfg_stop_xfer | input | 1 | Stop-at-transfer value written |
| clr_eor | input | 1 | Write-1 clear of eor_irq |
| clr_eot | input | 1 | Write-1 clear of eot_irq |
| clr_err | input | 1 | Write-1 clear of mode_err |
| in_valid | input | 1 | Input FIFO has a byte |
| in_data | input | 8 | Input byte |
| in_eor | input | 1 | Input byte ends a record |
| in_eot | input | 1 | Input byte ends a transfer |
| in_ready | output | 1 | Input byte taken this cycle when in_valid |
| core_valid | output | 1 | Byte offered to core |
| core_data | output | 8 | Byte to core |
| core_eor | output | 1 | Record tag to core |
| core_eot | output | 1 | Transfer tag to core |
| core_ready | input | 1 | Core accepts byte |
| res_valid | input | 1 | Core result available |
| res_data | input | 8 | Core result byte |
| res_eor | input | 1 | Result record tag |
| res_eot | input | 1 | Result transfer tag |
| res_ready | output | 1 | Result taken |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_eor | output | 1 | Output record tag |
| out_eot | output | 1 | Output transfer tag |
| out_ready | input | 1 | Output FIFO not full |
| run | output | 1 | Run enable readback |
| bypass | output | 1 | Bypass select readback |
| stop_rec | output | 1 | Stop-at-record readback |
| stop_xfer | output | 1 | Stop-at-transfer readback |
| empty | output | 1 | No bytes in flight |
| standby | output | 1 | Enabled but stalled this cycle |
| dict_clr | output | 1 | Dictionary reset strobe |
| eor_irq | output | 1 | Sticky end-of-record flag |
| eot_irq | output | 1 | Sticky end-of-transfer flag |
| mode_err | output | 1 | Sticky refused mode write |
| byte_cnt | output | CNT_W | Output byte count |

## Verification
A wrong in-flight count shows on empty within one cycle of the byte that upset it. It then stays wrong until reset, so the next drained idle period exposes it. A lost or wrong halt decision shows the cycle after the tagged byte is taken: either run stays 1 or the input FIFO index moves past the boundary. A bad bypass register shows on the first byte that follows, as data on core_data instead of the output, or as output data that differs from the input. A missed counter clear shows on byte_cnt at the first restart after a transfer halt.

// File: rtl/stream_chan_ctl.sv
module stream_chan_ctl #(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_run,
  input  logic             cfg_bypass,
  input  logic             cfg_stop_rec,
  input  logic             cfg_stop_xfer,
  input  logic             clr_eor,
  input  logic             clr_eot,
  input  logic             clr_err,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_eor,
  input  logic             in_eot,
  output logic             in_ready,
  output logic             core_valid,
  output logic [7:0]       core_data,
  output logic             core_eor,
  output logic             core_eot,
  input  logic             core_ready,
  input  logic             res_valid,
  input  logic [7:0]       res_data,
  input  logic             res_eor,
  input  logic             res_eot,
  output logic             res_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_eor,
  output logic             out_eot,
  input  logic             out_ready,
  output logic             run,
  output logic             bypass,
  output logic             stop_rec,
  output logic             stop_xfer,
  output logic             empty,
  output logic             standby,
  output logic             dict_clr,
  output logic             eor_irq,
  output logic             eot_irq,
  output logic             mode_err,
  output logic [CNT_W-1:0] byte_cnt
);

  logic             run_q, byp_q, srec_q, sxfer_q, xhalt_q;
  logic             dclr_q, eor_q, eot_q, err_q;
  logic             hb_v, hb_eor, hb_eot;
  logic [7:0]       hb_d;
  logic [FLT_W-1:0] flt_q;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready   = run_q & (byp_q ? (!hb_v | out_ready) : core_ready);
  assign core_valid = run_q & !byp_q & in_valid;
  assign core_data  = in_data;
  assign core_eor   = in_eor;
  assign core_eot   = in_eot;
  assign res_ready  = !byp_q & out_ready;

  assign out_valid = byp_q ? hb_v   : res_valid;
  assign out_data  = byp_q ? hb_d   : res_data;
  assign out_eor   = byp_q ? hb_eor : res_eor;
  assign out_eot   = byp_q ? hb_eot : res_eot;

  wire pop      = in_valid & in_ready;
  wire push     = out_valid & out_ready;
  wire halt     = pop & ((srec_q & (in_eor | in_eot)) | (sxfer_q & in_eot));
  wire mode_try = cfg_we & (cfg_bypass != byp_q);
  wire locked   = run_q | (flt_q != '0);
  wire run_rise = cfg_we & cfg_run & !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      byp_q   <= 1'b0;
      srec_q  <= 1'b0;
      sxfer_q <= 1'b0;
      xhalt_q <= 1'b0;
      dclr_q  <= 1'b0;
      eor_q   <= 1'b0;
      eot_q   <= 1'b0;
      err_q   <= 1'b0;
      hb_v    <= 1'b0;
      hb_d    <= '0;
      hb_eor  <= 1'b0;
      hb_eot  <= 1'b0;
      flt_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (cfg_we) begin
        run_q   <= cfg_run;
        srec_q  <= cfg_stop_rec;
        sxfer_q <= cfg_stop_xfer;
      end
      if (halt) run_q <= 1'b0;

      dclr_q <= mode_try & !locked;
      if (mode_try & !locked) byp_q <= cfg_bypass;

      if (mode_try & locked) err_q <= 1'b1;
      else if (clr_err)      err_q <= 1'b0;

      if (halt & in_eot)  xhalt_q <= 1'b1;
      else if (run_rise)  xhalt_q <= 1'b0;

      if (run_rise & xhalt_q) cnt_q <= push ? CNT_W'(1) : '0;
      else if (push)          cnt_q <= cnt_q + CNT_W'(1);

      flt_q <= flt_q + FLT_W'(pop) - FLT_W'(push);

      if (byp_q) begin
        if (push) hb_v <= 1'b0;
        if (pop) begin
          hb_v   <= 1'b1;
          hb_d   <= in_data;
          hb_eor <= in_eor;
          hb_eot <= in_eot;
        end
      end

      if (push & (out_eor | out_eot)) eor_q <= 1'b1;
      else if (clr_eor)               eor_q <= 1'b0;
      if (push & out_eot)             eot_q <= 1'b1;
      else if (clr_eot)               eot_q <= 1'b0;
    end
  end

  assign run       = run_q;
  assign bypass    = byp_q;
  assign stop_rec  = srec_q;
  assign stop_xfer = sxfer_q;
  assign empty     = (flt_q == '0);
  assign standby   = run_q & !pop & !push;
  assign dict_clr  = dclr_q;
  assign eor_irq   = eor_q;
  assign eot_irq   = eot_q;
  assign mode_err  = err_q;
  assign byte_cnt  = cnt_q;

endmodule

module stream_chan_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic bypass,
  input logic empty,
  input logic stop_rec,
  input logic stop_xfer,
  input logic in_valid,
  input logic in_ready,
  input logic in_eor,
  input logic in_eot,
  input logic core_valid,
  input logic cfg_we,
  input logic cfg_bypass,
  input logic dict_clr,
  input logic out_valid,
  input logic out_ready,
  input logic out_eot,
  input logic eot_irq,
  input logic mode_err
);
  // R2
  no_pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !in_ready);
  // R3
  byp_core_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> !core_valid);
  // R5
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_bypass != bypass) && (run || !empty)) |=> ($stable(bypass) && mode_err));
  // R6
  dict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dict_clr |-> (bypass != $past(bypass)));
  // R7
  stop_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && stop_rec && (in_eor || in_eot)) |=> (!run && !in_ready));
  // R8
  stop_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && stop_xfer && in_eot) |=> (!run && !in_ready));
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !empty);
  // R12
  eot_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eot) |=> eot_irq);
endmodule

bind stream_chan_ctl stream_chan_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .bypass(bypass), .empty(empty),
  .stop_rec(stop_rec), .stop_xfer(stop_xfer), .in_valid(in_valid),
  .in_ready(in_ready), .in_eor(in_eor), .in_eot(in_eot),
  .core_valid(core_valid), .cfg_we(cfg_we), .cfg_bypass(cfg_bypass),
  .dict_clr(dict_clr), .out_valid(out_valid), .out_ready(out_ready),
  .out_eot(out_eot), .eot_irq(eot_irq), .mode_err(mode_err)
);

// File: tb/stream_chan_ctl_tb.sv
module stream_chan_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_we = 0, cfg_run = 0, cfg_bypass = 0, cfg_stop_rec = 0, cfg_stop_xfer = 0;
  logic clr_eor = 0, clr_eot = 0, clr_err = 0;
  logic in_valid, in_eor, in_eot, in_ready;
  logic [7:0] in_data;
  logic core_valid, core_eor, core_eot, core_ready;
  logic [7:0] core_data;
  logic res_valid, res_eor, res_eot, res_ready;
  logic [7:0] res_data;
  logic out_valid, out_eor, out_eot;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic run, bypass, stop_rec, stop_xfer, empty, standby, dict_clr, eor_irq, eot_irq, mode_err;
  logic [15:0] byte_cnt;

  logic [7:0] src_d [64];
  logic       src_r [64];
  logic       src_t [64];
  int src_n = 0;
  int src_i = 0;
  logic [7:0] snk_d [64];
  int snk_n = 0;
  int dclr_n = 0;
  int core_n = 0;
  logic cv, ce, ct;
  logic [7:0] cd;

  assign in_valid   = src_i < src_n;
  assign in_data    = src_d[src_i];
  assign in_eor     = src_r[src_i];
  assign in_eot     = src_t[src_i];
  assign core_ready = !cv;
  assign res_valid  = cv;
  assign res_data   = cd;
  assign res_eor    = ce;
  assign res_eot    = ct;

  stream_chan_ctl u_dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      cv <= 1'b0; cd <= '0; ce <= 1'b0; ct <= 1'b0;
    end else begin
      if (in_valid && in_ready) src_i <= src_i + 1;
      if (out_valid && out_ready) begin
        snk_d[snk_n] <= out_data;
        snk_n <= snk_n + 1;
      end
      if (dict_clr) dclr_n <= dclr_n + 1;
      if (core_valid) core_n <= core_n + 1;
      if (res_valid && res_ready) cv <= 1'b0;
      if (core_valid && core_ready) begin
        cv <= 1'b1; cd <= ~core_data; ce <= core_eor; ct <= core_eot;
      end
    end
  end

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic r, input logic b, input logic sr, input logic sx);
    @(negedge clk);
    cfg_run = r; cfg_bypass = b; cfg_stop_rec = sr; cfg_stop_xfer = sx; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_clr(input int which);
    @(negedge clk);
    clr_eor = (which == 0); clr_eot = (which == 1); clr_err = (which == 2);
    @(negedge clk);
    clr_eor = 0; clr_eot = 0; clr_err = 0;
  endtask

  task automatic put(input logic [7:0] d, input logic r, input logic t);
    src_d[src_n] = d; src_r[src_n] = r; src_t[src_n] = t;
    src_n++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 run", run, 0);
    chk("R1 bypass", bypass, 0);
    chk("R1 empty", empty, 1);
    chk("R1 byte_cnt", byte_cnt, 0);
    chk("R1 flags", {eor_irq, eot_irq, mode_err}, 0);
    chk("R1 in_ready", in_ready, 0);
  endtask

  task automatic t_idle;
    put(8'hA1, 0, 0); put(8'hA2, 0, 0); put(8'hA3, 0, 0);
    idle(5);
    chk("R2 no pop while stopped", src_i, 0);
    chk("R2 in_ready low", in_ready, 0);
  endtask

  task automatic t_bypass;
    int d0, c0;
    d0 = dclr_n;
    wcfg(0, 1, 0, 0);
    chk("R6 bypass accepted", bypass, 1);
    idle(2);
    chk("R6 one strobe", dclr_n - d0, 1);
    c0 = core_n;
    wcfg(1, 1, 0, 0);
    idle(10);
    chk("R2 bytes taken", src_i, 3);
    chk("R3 byte0", snk_d[0], 8'hA1);
    chk("R3 byte1", snk_d[1], 8'hA2);
    chk("R3 byte2", snk_d[2], 8'hA3);
    chk("R3 core quiet", core_n - c0, 0);
    chk("R11 count", byte_cnt, 3);
    chk("R9 drained", empty, 1);
    chk("R6 run toggle no strobe", dclr_n - d0, 1);
  endtask

  task automatic t_lock;
    int d0;
    d0 = dclr_n;
    wcfg(1, 0, 0, 0);
    chk("R5 bypass kept", bypass, 1);
    chk("R5 err set", mode_err, 1);
    idle(2);
    chk("R6 no strobe on refused write", dclr_n - d0, 0);
    pulse_clr(2);
    chk("R5 err cleared", mode_err, 0);
  endtask

  task automatic t_stop_rec;
    wcfg(0, 1, 1, 0);
    put(8'hB1, 0, 0); put(8'hB2, 1, 0); put(8'hB3, 0, 0); put(8'hB4, 0, 0);
    wcfg(1, 1, 1, 0);
    idle(10);
    chk("R7 stopped after record end", src_i, 5);
    chk("R7 run cleared", run, 0);
    chk("R12 eor flag", eor_irq, 1);
    chk("R12 eot flag clear", eot_irq, 0);
    chk("R11 count at record pause", byte_cnt, 5);
    chk("R9 empty after pause", empty, 1);
    pulse_clr(0);
    chk("R12 eor cleared", eor_irq, 0);
    wcfg(1, 1, 1, 0);
    idle(10);
    chk("R7 restart drains rest", src_i, 7);
    chk("R11 not cleared after record halt", byte_cnt, 7);
    chk("R3 byte after restart", snk_d[6], 8'hB4);
    wcfg(0, 1, 0, 0);
  endtask

  task automatic t_core;
    int d0;
    d0 = dclr_n;
    wcfg(0, 0, 0, 0);
    idle(2);
    chk("R6 strobe on mode change", dclr_n - d0, 1);
    put(8'h12, 0, 0); put(8'h34, 0, 0); put(8'h56, 1, 0);
    wcfg(1, 0, 0, 0);
    idle(12);
    chk("R4 result0", snk_d[7], 8'hED);
    chk("R4 result1", snk_d[8], 8'hCB);
    chk("R4 result2", snk_d[9], 8'hA9);
    chk("R11 count", byte_cnt, 10);
    chk("R12 eor from core tag", eor_irq, 1);
    pulse_clr(0);
  endtask

  task automatic t_stop_xfer;
    wcfg(0, 0, 0, 1);
    put(8'hD1, 1, 0); put(8'hD2, 0, 0); put(8'hD3, 1, 1); put(8'hD4, 0, 0);
    wcfg(1, 0, 0, 1);
    idle(15);
    chk("R8 stopped after transfer end", src_i, 13);
    chk("R8 run cleared", run, 0);
    chk("R12 eot flag", eot_irq, 1);
    chk("R11 count at transfer end", byte_cnt, 13);
    pulse_clr(1);
    chk("R12 eot cleared", eot_irq, 0);
    wcfg(1, 0, 0, 0);
    chk("R11 cleared on restart", byte_cnt, 0);
    idle(8);
    chk("R11 counts after clear", byte_cnt, 1);
    chk("R4 last result", snk_d[13], 8'h2B);
  endtask

  task automatic t_standby;
    idle(2);
    chk("R10 starved", standby, 1);
    out_ready = 0;
    put(8'hE1, 0, 0); put(8'hE2, 0, 0);
    idle(5);
    chk("R10 blocked", standby, 1);
    chk("R9 busy while blocked", empty, 0);
    out_ready = 1;
    idle(10);
    chk("R9 empty after drain", empty, 1);
    chk("R4 drained result", snk_d[15], 8'h1D);
    chk("R11 count", byte_cnt, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_idle;
    t_bypass;
    t_lock;
    t_stop_rec;
    t_core;
    t_stop_xfer;
    t_standby;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule